// File: doc/BRIEF.md
# Open-Row-Aware Memory Request Scheduler

This block sits between the request sources of a memory controller and its command generator. It holds up to eight pending requests, each naming a bank, a row, a column and a direction (read or write). Whenever the command generator accepts a request, the scheduler hands over the best-ranked pending entry rather than the oldest one.

Ranking uses the row each bank currently has open, which the command generator reports on a small update port. It also uses the direction of the most recently issued request. An entry that has been passed over 64 times jumps to the front, so no request is starved. A write may never overtake an older pending read to the very same location.

Top module: `rowpick_sched`

## Requirements
- R1: The queue holds at most 8 entries; while 8 are held `in_ready` is low and an offered request is dropped, so only the 8 stored ones are ever issued.
- R2: After reset `out_valid` is 0 and `in_ready` is 1; `out_valid` is high exactly while at least one entry is queued.
- R3: An entry whose row equals the open row of its bank (a hit) is issued before any non-hit entry that is not starved, even a non-hit entry that is older.
- R4: Hits are judged per bank: a row number counts as a hit only against the row open in that entry's own bank.
- R5: Below hits, an entry whose direction (`wr` 1 = write, 0 = read) equals that of the last issued request ranks higher. The direction record is empty after reset and after any cycle in which the queue is empty; while empty it favours neither direction.
- R6: Below direction, reads rank above writes.
- R7: Entries of equal rank are issued oldest first.
- R8: An entry that stays queued through 64 issues of other entries ranks above all entries that are not starved.
- R9: A write with the same bank, row and column as an older queued read is not issued before that read; other writes are unaffected.
- R10: When `upd_en` is high at a clock edge, bank `upd_bank` gets open row `upd_row` if `upd_open` is 1, and no open row if it is 0. The change applies to selections from the next cycle on.
- R11: An enqueue and a dequeue in the same cycle are both performed, and the entry count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New request offered |
| in_ready | output | 1 | Queue can accept a request |
| in_bank | input | 3 | Bank of the offered request |
| in_row | input | 8 | Row of the offered request |
| in_col | input | 6 | Column of the offered request |
| in_wr | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | A selected request is presented |
| out_ready | input | 1 | Command generator takes the request |
| out_bank | output | 3 | Bank of the selected request |
| out_row | output | 8 | Row of the selected request |
| out_col | output | 6 | Column of the selected request |
| out_wr | output | 1 | Direction of the selected request |
| upd_en | input | 1 | Open-row table update strobe |
| upd_open | input | 1 | 1 = row opened, 0 = bank closed |
| upd_bank | input | 3 | Bank being updated |
| upd_row | input | 8 | Row now open in that bank |

## Verification
Several queue mixes are used. Identical reads with no open rows test age order. An older miss next to a younger hit tests hit preference. Equal row numbers in different banks show whether hits are judged per bank. After a bank is closed, its former hit must lose its preference. Mixed reads and writes, issued before and after a turnaround, separate the direction rule from the read-over-write rule. A hit write followed by a same-address read/write pair shows that the blocking rule is exact-match only. A steady stream of hits behind one old miss must release the miss on exactly the 65th issue.

// File: rtl/rowpick_sched.sv
module rowpick_sched #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int STARVE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic              in_wr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic              out_wr,
  input  logic              upd_en,
  input  logic              upd_open,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);
  localparam int NBANK = 1 << BANK_W;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int IW    = $clog2(DEPTH);
  localparam int AW    = $clog2(STARVE + 1);

  logic [CW-1:0]     cnt;
  logic [BANK_W-1:0] q_bank [DEPTH];
  logic [ROW_W-1:0]  q_row  [DEPTH];
  logic [COL_W-1:0]  q_col  [DEPTH];
  logic [AW-1:0]     q_age  [DEPTH];
  logic [DEPTH-1:0]  q_wr;
  logic [NBANK-1:0]  open_v;
  logic [ROW_W-1:0]  open_row [NBANK];
  logic              last_v, last_wr;

  logic [DEPTH-1:0]  live, blk, hit, starv;
  logic [3:0]        score [DEPTH];
  logic [3:0]        best;
  logic [IW-1:0]     sel;

  logic [BANK_W-1:0] n_bank [DEPTH];
  logic [ROW_W-1:0]  n_row  [DEPTH];
  logic [COL_W-1:0]  n_col  [DEPTH];
  logic [AW-1:0]     n_age  [DEPTH];
  logic [DEPTH-1:0]  n_wr;
  logic [CW-1:0]     pos;

  assign in_ready  = cnt < CW'(DEPTH);
  assign out_valid = cnt != '0;
  wire fire_in  = in_valid && in_ready;
  wire fire_out = out_valid && out_ready;

  assign out_bank = q_bank[sel];
  assign out_row  = q_row[sel];
  assign out_col  = q_col[sel];
  assign out_wr   = q_wr[sel];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i]  = CW'(i) < cnt;
      hit[i]   = open_v[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
      starv[i] = q_age[i] >= AW'(STARVE);
      score[i] = {starv[i], hit[i], last_v && (q_wr[i] == last_wr), !q_wr[i]};
      blk[i]   = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && live[j] && !q_wr[j] && q_wr[i] && q_bank[j] == q_bank[i] &&
            q_row[j] == q_row[i] && q_col[j] == q_col[i])
          blk[i] = 1'b1;
    end
  end

  always_comb begin
    sel  = '0;
    best = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (live[i] && !blk[i] && score[i] >= best) begin
        sel  = IW'(i);
        best = score[i];
      end
  end

  assign pos = cnt - CW'(fire_out);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = (fire_out && i >= int'(sel)) ? (i + 1) % DEPTH : i;
      n_bank[i] = q_bank[s];
      n_row[i]  = q_row[s];
      n_col[i]  = q_col[s];
      n_wr[i]   = q_wr[s];
      n_age[i]  = (fire_out && q_age[s] < AW'(STARVE)) ? q_age[s] + AW'(1) : q_age[s];
      if (fire_in && CW'(i) == pos) begin
        n_bank[i] = in_bank;
        n_row[i]  = in_row;
        n_col[i]  = in_col;
        n_wr[i]   = in_wr;
        n_age[i]  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      open_v  <= '0;
      last_v  <= 1'b0;
      last_wr <= 1'b0;
    end else begin
      cnt <= cnt + CW'(fire_in) - CW'(fire_out);
      if (upd_en) open_v[upd_bank] <= upd_open;
      if (fire_out) begin
        last_v  <= 1'b1;
        last_wr <= q_wr[sel];
      end else if (cnt == '0) begin
        last_v  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) open_row[upd_bank] <= upd_row;
    q_bank <= n_bank;
    q_row  <= n_row;
    q_col  <= n_col;
    q_age  <= n_age;
    q_wr   <= n_wr;
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_ready) |=> cnt == $past(cnt));
  p_keep_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_hit_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && |(live & ~blk & hit) && !(|(live & starv))) |-> hit[sel]);
  p_starve_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && |(live & ~blk & starv)) |-> starv[sel]);
  p_no_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !blk[sel]);
  p_both_ways_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && fire_out) |=> cnt == $past(cnt));
endmodule

// File: tb/test_rowpick_sched.sv
module test_rowpick_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_wr = 1'b0;
  logic [2:0] in_bank = '0;
  logic [7:0] in_row = '0;
  logic [5:0] in_col = '0;
  logic       in_ready, out_valid, out_wr;
  logic       out_ready = 1'b0;
  logic [2:0] out_bank;
  logic [7:0] out_row;
  logic [5:0] out_col;
  logic       upd_en = 1'b0, upd_open = 1'b0;
  logic [2:0] upd_bank = '0;
  logic [7:0] upd_row = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rowpick_sched i_rowpick_sched (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_bank(in_bank), .in_row(in_row),
    .in_col(in_col), .in_wr(in_wr),
    .out_valid(out_valid), .out_ready(out_ready), .out_bank(out_bank), .out_row(out_row),
    .out_col(out_col), .out_wr(out_wr),
    .upd_en(upd_en), .upd_open(upd_open), .upd_bank(upd_bank), .upd_row(upd_row)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic enq(input int b, input int r, input int c, input bit w);
    @(negedge clk);
    in_valid = 1'b1; in_bank = 3'(b); in_row = 8'(r); in_col = 6'(c); in_wr = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_row(input int b, input int r, input bit o);
    @(negedge clk);
    upd_en = 1'b1; upd_bank = 3'(b); upd_row = 8'(r); upd_open = o;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic pop(output int c, output bit w, output bit ok);
    @(negedge clk);
    ok = out_valid; c = int'(out_col); w = out_wr;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_pop(input int c, input bit w, input string tag);
    int ac; bit aw; bit ok;
    pop(ac, aw, ok);
    check(ok && ac == c && aw == w, tag, ok ? ac * 2 + int'(aw) : -1, c * 2 + int'(w));
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R2 reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R2 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_full;
    for (int k = 0; k < 8; k++) enq(1, 10 + k, k, 1'b0);
    check(in_ready == 1'b0, "R1 full refuses", int'(in_ready), 0);
    enq(1, 50, 8, 1'b0);
    for (int k = 0; k < 8; k++) expect_pop(k, 1'b0, "R7 oldest first");
    check(out_valid == 1'b0, "R1 dropped entry absent / R2 empty", int'(out_valid), 0);
  endtask

  task automatic t_hit;
    set_row(2, 7, 1'b1);
    enq(2, 3, 1, 1'b0);
    enq(2, 7, 2, 1'b0);
    expect_pop(2, 1'b0, "R3 hit before older miss");
    expect_pop(1, 1'b0, "R3 miss afterwards");
  endtask

  task automatic t_bank;
    enq(3, 7, 3, 1'b0);
    enq(2, 7, 4, 1'b0);
    expect_pop(4, 1'b0, "R4 hit judged in own bank");
    expect_pop(3, 1'b0, "R4 other bank follows");
  endtask

  task automatic t_close;
    set_row(2, 0, 1'b0);
    enq(2, 1, 5, 1'b0);
    enq(2, 7, 6, 1'b0);
    expect_pop(5, 1'b0, "R10 closed bank gives no hit");
    expect_pop(6, 1'b0, "R10 second");
  endtask

  task automatic t_dir;
    enq(4, 1, 7, 1'b1);
    enq(4, 2, 8, 1'b0);
    expect_pop(8, 1'b0, "R6 read over write");
    enq(4, 3, 9, 1'b0);
    enq(4, 4, 10, 1'b1);
    expect_pop(9, 1'b0, "R5 read follows read");
    expect_pop(7, 1'b1, "R7 older of equal writes");
    enq(4, 5, 11, 1'b0);
    expect_pop(10, 1'b1, "R5 write follows write");
    expect_pop(11, 1'b0, "R5 read last");
  endtask

  task automatic t_raw;
    set_row(6, 0, 1'b1);
    enq(6, 0, 13, 1'b1);
    enq(5, 6, 12, 1'b0);
    enq(5, 6, 12, 1'b1);
    enq(5, 6, 14, 1'b1);
    expect_pop(13, 1'b1, "R9 hit write first");
    expect_pop(14, 1'b1, "R9 other-column write free");
    expect_pop(12, 1'b0, "R9 read before same-address write");
    expect_pop(12, 1'b1, "R9 write after read");
  endtask

  task automatic t_starve;
    int n; bit found; int c; bit w; bit ok;
    n = 0; found = 1'b0;
    set_row(7, 1, 1'b1);
    enq(7, 2, 20, 1'b0);
    for (int k = 0; k < 7; k++) enq(7, 1, 30 + k, 1'b0);
    for (int k = 0; k < 80 && !found; k++) begin
      pop(c, w, ok);
      n++;
      if (ok && c == 20) found = 1'b1;
      else enq(7, 1, 30 + ((k + 7) % 30), 1'b0);
    end
    check(found && n == 65, "R8 starved miss issued at 65th", n, 65);
    for (int k = 0; k < 7; k++) pop(c, w, ok);
    check(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
  endtask

  task automatic t_simul;
    int c;
    enq(0, 0, 40, 1'b0);
    enq(0, 0, 41, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_bank = 3'd0; in_row = 8'd0; in_col = 6'd42; in_wr = 1'b0;
    out_ready = 1'b1;
    c = int'(out_col);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    check(c == 40, "R11 dequeue while enqueue", c, 40);
    expect_pop(41, 1'b0, "R11 kept entry");
    expect_pop(42, 1'b0, "R11 added entry");
    check(out_valid == 1'b0, "R11 count unchanged", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full;
    t_hit;
    t_bank;
    t_close;
    t_dir;
    t_raw;
    t_starve;
    t_simul;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule